// File: doc/BRIEF.md
# Power-Mode Clock Policy Controller

This block decides how the clocks of a small controller subsystem behave in each of ten operating modes. Software places a mode code on `req_mode` and pulses `req_valid` while the subsystem is running. The block then drives the fast oscillator enable and the rate selects for the main and low-power clock domains. It also drives the gating enables for the CPU, the main clock, the memories, the main-domain peripherals and each low-power-domain peripheral.

The block records which run mode it left. A later wake returns to that run mode. The same record selects the clock state kept in the shallow stop mode. Wake sources are filtered by depth. Any interrupt ends a sleep mode. Only low-power-domain interrupts end a stop or standby mode. In the deepest standby mode only one always-on timer keeps its clock. Any other low-power peripheral can regain its clock for as long as it holds an asynchronous fast-clock request.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is RUN0 (code 0). The rate outputs are `sysosc_en`=1, `mclk_fast`=1 and `ulp_rate`=2. Every gate output is 1, and `req_err`=0 and `wake_pulse`=0.
- R2: Mode codes are RUN0=0, RUN1=1, RUN2=2, SLEEP0=3, SLEEP1=4, SLEEP2=5, STOP0=6, STOP2=7, STANDBY0=8, STANDBY1=9. A `req_valid` with a code from 0 to 9 while `mode_o` is 0, 1 or 2 sets `mode_o` to that code on the next clock.
- R3: The rate group is (`sysosc_en`, `mclk_fast`, `ulp_rate`). The `ulp_rate` encoding is 0=32 kHz, 1=4 MHz, 2=32 MHz. The values are: RUN0 (1,1,2); RUN1 (1,0,0); RUN2 (0,0,0); SLEEP0 (1,1,2); SLEEP1 (1,0,0); SLEEP2 (0,0,0); STOP2, STANDBY0 and STANDBY1 (0,0,0).
- R4: The gate group is (`cpu_clk_en`, `mclk_en`, `mem_clk_en`, `main_periph_en`, all of `lp_periph_en`). The values are: run modes (1,1,1,1,1); sleep modes (0,1,1,1,1); STOP0, STOP2 and STANDBY0 (0,0,0,0,1); STANDBY1 (0,0,0,0,0). In STANDBY1 the always-on bit `lp_periph_en[AON_IDX]` (bit 0 by default) stays 1.
- R5: STOP0 rates depend on the run mode it was entered from. From RUN0 they are (1,0,1). From RUN1 they are (1,0,0). From RUN2 they are (0,0,0).
- R6: The rate group takes a new mode's values one clock after `mode_o` changes. The gate group takes them one clock later still.
- R7: In a sleep mode, any bit of `irq_main` or `irq_lp` causes a wake on the next clock.
- R8: In a stop or standby mode, `irq_main` has no effect. Only a bit of `irq_lp` causes a wake.
- R9: On a wake, `mode_o` returns to the run mode recorded on entry. `wake_pulse` is 1 for exactly that one clock.
- R10: A `req_valid` outside a run mode, or one carrying a code above 9, leaves `mode_o` unchanged. It sets `req_err`, which stays set until reset.
- R11: In STANDBY1, a `fast_req[i]` held high turns on `lp_periph_en[i]` after `SYNC_STAGES` clocks (2 by default). The bit turns off again the same number of clocks after `fast_req[i]` is released.
- R12: In a run mode, interrupts change neither `mode_o` nor `wake_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 4 | Requested mode code |
| irq_main | input | N_MAIN_IRQ | Enabled main-domain interrupts |
| irq_lp | input | N_LP_IRQ | Enabled low-power-domain interrupts |
| fast_req | input | N_LP_PERIPH | Asynchronous fast-clock requests from low-power peripherals |
| mode_o | output | 4 | Current mode code |
| sysosc_en | output | 1 | Fast oscillator enable |
| mclk_fast | output | 1 | Main/CPU clock rate select, 1 = 32 MHz |
| ulp_rate | output | 2 | Low-power clock rate select |
| cpu_clk_en | output | 1 | CPU clock gate |
| mclk_en | output | 1 | Main-domain clock gate |
| mem_clk_en | output | 1 | Memory clock gate |
| main_periph_en | output | 1 | Main-domain peripheral clock gate |
| lp_periph_en | output | N_LP_PERIPH | Per-peripheral low-power clock gates |
| wake_pulse | output | 1 | One-clock wake indication |
| req_err | output | 1 | Sticky rejected-request flag |

## Verification
A table drives entries into every sleep, stop and standby mode, and a run-to-run change, each from a chosen run mode. STOP0 is entered from all three run modes, which is the only way to separate the origin-dependent policy from a fixed per-mode policy. Sleep exits use main-domain interrupts and deep exits use low-power ones. Each case samples the outputs one clock and two clocks after the mode changes, which shows whether the rates move before the gates. Directed cases add the following:
- a main interrupt in STOP2, to test domain filtering;
- requests made in sleep and with an out-of-range code;
- a fast-clock request in STANDBY1, timed against the synchronizer depth.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [3:0] {
      M_RUN0 = 4'd0, M_RUN1 = 4'd1, M_RUN2 = 4'd2,
      M_SLP0 = 4'd3, M_SLP1 = 4'd4, M_SLP2 = 4'd5,
      M_STP0 = 4'd6, M_STP2 = 4'd7,
      M_SBY0 = 4'd8, M_SBY1 = 4'd9
   } mode_e;

   localparam logic [1:0] ULP_32K = 2'd0;
   localparam logic [1:0] ULP_4M  = 2'd1;
   localparam logic [1:0] ULP_32M = 2'd2;

   typedef struct packed {
      logic       osc_en;
      logic       mclk_fast;
      logic [1:0] ulp_rate;
   } rate_t;

   typedef struct packed {
      logic cpu_en;
      logic mclk_en;
      logic mem_en;
      logic main_en;
      logic lp_en;
      logic fast_ok;
   } gate_t;

   function automatic logic is_run(input mode_e m);
      return (m == M_RUN0) || (m == M_RUN1) || (m == M_RUN2);
   endfunction

   function automatic logic is_sleep(input mode_e m);
      return (m == M_SLP0) || (m == M_SLP1) || (m == M_SLP2);
   endfunction

   function automatic logic code_ok(input logic [3:0] c);
      return c <= 4'd9;
   endfunction

   function automatic rate_t rate_of(input mode_e m, input mode_e origin);
      rate_t r;
      r.osc_en    = 1'b0;
      r.mclk_fast = 1'b0;
      r.ulp_rate  = ULP_32K;
      case (m)
         M_RUN0, M_SLP0: begin
            r.osc_en    = 1'b1;
            r.mclk_fast = 1'b1;
            r.ulp_rate  = ULP_32M;
         end
         M_RUN1, M_SLP1: r.osc_en = 1'b1;
         M_STP0: begin
            if (origin == M_RUN0) begin
               r.osc_en   = 1'b1;
               r.ulp_rate = ULP_4M;
            end else if (origin == M_RUN1) begin
               r.osc_en = 1'b1;
            end
         end
         default: r.osc_en = 1'b0;
      endcase
      return r;
   endfunction

   function automatic gate_t gate_of(input mode_e m);
      gate_t g;
      g.cpu_en  = is_run(m);
      g.mclk_en = is_run(m) || is_sleep(m);
      g.mem_en  = is_run(m) || is_sleep(m);
      g.main_en = is_run(m) || is_sleep(m);
      g.lp_en   = (m != M_SBY1);
      g.fast_ok = (m == M_SBY1);
      return g;
   endfunction

endpackage

// File: rtl/pmc_req_sync.sv
module pmc_req_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pmc_wake_filter.sv
module pmc_wake_filter
   import pmc_pkg::*;
#(
   parameter int N_MAIN_IRQ = 8,
   parameter int N_LP_IRQ   = 4
) (
   input  mode_e                 mode,
   input  logic [N_MAIN_IRQ-1:0] irq_main,
   input  logic [N_LP_IRQ-1:0]   irq_lp,
   output logic                  wake
);

   logic any_main;
   logic any_lp;

   assign any_main = |irq_main;
   assign any_lp   = |irq_lp;

   always_comb begin
      if (is_run(mode))        wake = 1'b0;
      else if (is_sleep(mode)) wake = any_main | any_lp;
      else                     wake = any_lp;
   end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [3:0] req_mode,
   input  logic       wake,
   output mode_e      mode_q,
   output mode_e      origin_q,
   output logic       wake_pulse,
   output logic       req_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= M_RUN0;
         origin_q   <= M_RUN0;
         wake_pulse <= 1'b0;
         req_err    <= 1'b0;
      end else begin
         wake_pulse <= 1'b0;
         if (is_run(mode_q)) begin
            if (req_valid) begin
               if (code_ok(req_mode)) begin
                  mode_q   <= mode_e'(req_mode);
                  origin_q <= mode_q;
               end else begin
                  req_err <= 1'b1;
               end
            end
         end else begin
            if (req_valid) req_err <= 1'b1;
            if (wake) begin
               mode_q     <= origin_q;
               wake_pulse <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pmc_clk_policy.sv
module pmc_clk_policy
   import pmc_pkg::*;
#(
   parameter int N_LP_PERIPH = 4,
   parameter int AON_IDX     = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  mode_e                  mode,
   input  mode_e                  origin,
   input  logic [N_LP_PERIPH-1:0] req_sync,
   output rate_t                  rate_q,
   output gate_t                  gate_q,
   output logic [N_LP_PERIPH-1:0] lp_en
);

   mode_e mode_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= rate_of(M_RUN0, M_RUN0);
         mode_d <= M_RUN0;
         gate_q <= gate_of(M_RUN0);
      end else begin
         rate_q <= rate_of(mode, origin);
         mode_d <= mode;
         gate_q <= gate_of(mode_d);
      end
   end

   generate
      for (genvar i = 0; i < N_LP_PERIPH; i++) begin : g_lp
         if (i == AON_IDX) begin : g_aon
            assign lp_en[i] = 1'b1;
         end else begin : g_gated
            assign lp_en[i] = gate_q.lp_en | (gate_q.fast_ok & req_sync[i]);
         end
      end
   endgenerate

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int N_MAIN_IRQ  = 8,
   parameter int N_LP_IRQ    = 4,
   parameter int N_LP_PERIPH = 4,
   parameter int AON_IDX     = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [3:0]             req_mode,
   input  logic [N_MAIN_IRQ-1:0]  irq_main,
   input  logic [N_LP_IRQ-1:0]    irq_lp,
   input  logic [N_LP_PERIPH-1:0] fast_req,
   output logic [3:0]             mode_o,
   output logic                   sysosc_en,
   output logic                   mclk_fast,
   output logic [1:0]             ulp_rate,
   output logic                   cpu_clk_en,
   output logic                   mclk_en,
   output logic                   mem_clk_en,
   output logic                   main_periph_en,
   output logic [N_LP_PERIPH-1:0] lp_periph_en,
   output logic                   wake_pulse,
   output logic                   req_err
);

   generate
      if (N_MAIN_IRQ < 1 || N_LP_IRQ < 1) begin : g_bad_irq
         $error("interrupt vectors need at least one bit");
      end
      if (N_LP_PERIPH < 1 || AON_IDX < 0 || AON_IDX >= N_LP_PERIPH) begin : g_bad_aon
         $error("AON_IDX must select an existing low-power peripheral");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   mode_e                  mode_q;
   mode_e                  origin_q;
   logic                   wake;
   logic [N_LP_PERIPH-1:0] req_sync;
   rate_t                  rate_q;
   gate_t                  gate_q;

   pmc_wake_filter #(
      .N_MAIN_IRQ (N_MAIN_IRQ),
      .N_LP_IRQ   (N_LP_IRQ)
   ) u_wake (
      .mode     (mode_q),
      .irq_main (irq_main),
      .irq_lp   (irq_lp),
      .wake     (wake)
   );

   pmc_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_mode   (req_mode),
      .wake       (wake),
      .mode_q     (mode_q),
      .origin_q   (origin_q),
      .wake_pulse (wake_pulse),
      .req_err    (req_err)
   );

   pmc_req_sync #(
      .WIDTH  (N_LP_PERIPH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (fast_req),
      .sync_out (req_sync)
   );

   pmc_clk_policy #(
      .N_LP_PERIPH (N_LP_PERIPH),
      .AON_IDX     (AON_IDX)
   ) u_policy (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_q),
      .origin   (origin_q),
      .req_sync (req_sync),
      .rate_q   (rate_q),
      .gate_q   (gate_q),
      .lp_en    (lp_periph_en)
   );

   assign mode_o         = mode_q;
   assign sysosc_en      = rate_q.osc_en;
   assign mclk_fast      = rate_q.mclk_fast;
   assign ulp_rate       = rate_q.ulp_rate;
   assign cpu_clk_en     = gate_q.cpu_en;
   assign mclk_en        = gate_q.mclk_en;
   assign mem_clk_en     = gate_q.mem_en;
   assign main_periph_en = gate_q.main_en;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
   parameter int N_MAIN_IRQ = 8,
   parameter int N_LP_IRQ   = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [3:0]            req_mode,
   input logic [N_MAIN_IRQ-1:0] irq_main,
   input logic [N_LP_IRQ-1:0]   irq_lp,
   input logic [3:0]            mode_o,
   input logic                  sysosc_en,
   input logic [1:0]            ulp_rate,
   input logic                  cpu_clk_en,
   input logic                  mem_clk_en,
   input logic                  main_periph_en,
   input logic                  wake_pulse,
   input logic                  req_err
);

   a_r2_mode_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o <= 4'd9);

   a_r2_run_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode_o <= 4'd2 && req_mode <= 4'd9) |=> mode_o == $past(req_mode));

   a_r3_standby1_rates: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 4'd9 && $past(mode_o) == 4'd9) |-> (!sysosc_en && ulp_rate == 2'd0));

   a_r4_standby1_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 4'd9 && $past(mode_o) == 4'd9 && $past(mode_o, 2) == 4'd9)
      |-> (!cpu_clk_en && !mem_clk_en && !main_periph_en));

   a_r7_sleep_any_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o >= 4'd3 && mode_o <= 4'd5 && (|irq_main)) |=> wake_pulse);

   a_r8_deep_needs_lp_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o >= 4'd6 && irq_lp == '0) |=> !wake_pulse);

   a_r9_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   a_r9_wake_lands_run: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (mode_o <= 4'd2 && $past(mode_o) > 4'd2));

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |=> req_err);

   a_r10_flag_bad_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (mode_o > 4'd2 || req_mode > 4'd9)) |=> req_err);

   a_r12_run_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o <= 4'd2) |=> !wake_pulse);

endmodule

bind pwr_mode_ctrl pmc_checker #(
   .N_MAIN_IRQ (N_MAIN_IRQ),
   .N_LP_IRQ   (N_LP_IRQ)
) u_chk (.*);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

   localparam int NM = 8;
   localparam int NL = 4;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [3:0]    req_mode = '0;
   logic [NM-1:0] irq_main = '0;
   logic [NL-1:0] irq_lp = '0;
   logic [NP-1:0] fast_req = '0;
   logic [3:0]    mode_o;
   logic          sysosc_en, mclk_fast, cpu_clk_en, mclk_en, mem_clk_en, main_periph_en;
   logic [1:0]    ulp_rate;
   logic [NP-1:0] lp_periph_en;
   logic          wake_pulse, req_err;

   int checks = 0;
   int errors = 0;
   logic [3:0] cur;

   always #4 clk = ~clk;

   pwr_mode_ctrl u_pwr_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .irq_main(irq_main), .irq_lp(irq_lp), .fast_req(fast_req),
      .mode_o(mode_o), .sysosc_en(sysosc_en), .mclk_fast(mclk_fast),
      .ulp_rate(ulp_rate), .cpu_clk_en(cpu_clk_en), .mclk_en(mclk_en),
      .mem_clk_en(mem_clk_en), .main_periph_en(main_periph_en),
      .lp_periph_en(lp_periph_en), .wake_pulse(wake_pulse), .req_err(req_err)
   );

   typedef struct packed {
      logic [3:0] from;
      logic [3:0] to;
      logic       osc;
      logic       mf;
      logic [1:0] ulp;
      logic       cpu;
      logic       mc;
      logic       mem;
      logic       mn;
      logic       lp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 4'd3, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
      '{4'd0, 4'd6, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd1, 4'd6, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd2, 4'd6, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd1, 4'd4, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
      '{4'd2, 4'd5, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
      '{4'd0, 4'd7, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd1, 4'd8, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{4'd2, 4'd9, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{4'd0, 4'd2, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
      '{4'd0, 4'd5, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic request(input logic [3:0] code);
      req_valid = 1'b1;
      req_mode  = code;
      tick(1);
      req_valid = 1'b0;
   endtask

   task automatic go_run(input logic [3:0] m);
      if (cur != m) begin
         request(m);
         tick(2);
         cur = m;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      cur = 4'd0;
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cur = 4'd0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 mode", mode_o, 0);
      chk("R1 rates", {sysosc_en, mclk_fast, ulp_rate}, {1'b1, 1'b1, 2'd2});
      chk("R1 gates", {cpu_clk_en, mclk_en, mem_clk_en, main_periph_en, lp_periph_en},
          {4'b1111, 4'b1111});
      chk("R1 flags", {req_err, wake_pulse}, 2'b00);

      for (int v = 0; v < NV; v++) begin
         go_run(VECS[v].from);
         request(VECS[v].to);
         chk($sformatf("R2 mode v%0d", v), mode_o, VECS[v].to);
         tick(1);
         // R3 / R5 rates one cycle after the mode change
         chk($sformatf("R3 R5 rates v%0d", v), {sysosc_en, mclk_fast, ulp_rate},
             {VECS[v].osc, VECS[v].mf, VECS[v].ulp});
         // R6 gates still hold the previous run values
         chk($sformatf("R6 gate lag v%0d", v), cpu_clk_en, 1'b1);
         tick(1);
         chk($sformatf("R4 gates v%0d", v), {cpu_clk_en, mclk_en, mem_clk_en, main_periph_en},
             {VECS[v].cpu, VECS[v].mc, VECS[v].mem, VECS[v].mn});
         chk($sformatf("R4 lp v%0d", v), lp_periph_en, VECS[v].lp ? 4'b1111 : 4'b0001);
         if (VECS[v].to <= 4'd2) begin
            cur = VECS[v].to;
         end else begin
            if (VECS[v].to <= 4'd5) irq_main = 8'h10;   // R7 any irq wakes sleep
            else                    irq_lp   = 4'h2;    // R8 lp irq wakes deep modes
            tick(1);
            irq_main = '0;
            irq_lp   = '0;
            chk($sformatf("R9 return v%0d", v), mode_o, VECS[v].from);
            chk($sformatf("R7 R8 R9 pulse v%0d", v), wake_pulse, 1'b1);
            tick(1);
            chk($sformatf("R9 pulse width v%0d", v), wake_pulse, 1'b0);
            tick(1);
            chk($sformatf("R9 gates back v%0d", v), cpu_clk_en, 1'b1);
            cur = VECS[v].from;
         end
      end

      // R12: interrupts in a run mode do nothing
      go_run(4'd0);
      irq_main = '1;
      irq_lp   = '1;
      tick(2);
      irq_main = '0;
      irq_lp   = '0;
      chk("R12 mode", mode_o, 0);
      chk("R12 pulse", wake_pulse, 1'b0);

      // R8: main irq ignored in STOP2
      request(4'd7);
      irq_main = 8'hFF;
      tick(3);
      chk("R8 main ignored mode", mode_o, 7);
      chk("R8 main ignored pulse", wake_pulse, 1'b0);
      irq_main = '0;
      irq_lp   = 4'h1;
      tick(1);
      irq_lp = '0;
      chk("R8 lp wake", mode_o, 0);
      tick(2);

      // R10: request while sleeping ignored, error sticky
      chk("R10 err clear", req_err, 1'b0);
      request(4'd3);
      request(4'd1);
      chk("R10 sleep hold", mode_o, 3);
      chk("R10 err set", req_err, 1'b1);
      irq_lp = 4'h4;
      tick(1);
      irq_lp = '0;
      tick(3);
      chk("R10 err sticky", req_err, 1'b1);
      do_reset();
      chk("R1 err cleared", req_err, 1'b0);

      // R10: out-of-range code in run
      request(4'd12);
      chk("R10 bad code mode", mode_o, 0);
      chk("R10 bad code err", req_err, 1'b1);
      tick(2);
      chk("R10 bad code rates", {sysosc_en, mclk_fast, ulp_rate}, {1'b1, 1'b1, 2'd2});
      do_reset();

      // R11: fast-clock request in STANDBY1
      request(4'd9);
      tick(2);
      chk("R11 aon only", lp_periph_en, 4'b0001);
      fast_req = 4'b0100;
      tick(1);
      chk("R11 sync lag", lp_periph_en, 4'b0001);
      tick(1);
      chk("R11 request on", lp_periph_en, 4'b0101);
      fast_req = '0;
      tick(1);
      chk("R11 release lag", lp_periph_en, 4'b0101);
      tick(1);
      chk("R11 request off", lp_periph_en, 4'b0001);
      irq_lp = 4'h8;
      tick(1);
      irq_lp = '0;
      chk("R11 wake to RUN0", mode_o, 0);
      tick(2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule